// File: doc/BRIEF.md
# Tagged Dynamic Branch Direction Predictor

This block guesses whether a conditional branch will be taken, for use by a pipelined fetch unit that must choose its next fetch address before the branch resolves. It keeps a direct-mapped history table of 64 entries. Each entry holds a valid flag, the upper address bits of the branch that owns it (its tag) and a 2-bit history state. Instructions are 32-bit and word aligned, so the two lowest address bits are dropped. The next six bits pick the entry, and the remaining 24 bits form the tag.

A lookup presents the branch address and its target. If the selected entry is valid and its tag matches, the prediction is the entry's prediction bit. Otherwise a static rule applies: a branch whose target lies below its own address, such as a loop back-edge, is predicted taken, and any other branch is predicted not taken. Once the branch has resolved, an update presents its address and actual outcome. A matching entry steps its 2-bit state, so a single wrong guess does not overturn the prediction. A non-matching update claims the entry for that branch.

The 2-bit state is {prediction, last outcome}. The prediction changes only after two consecutive mispredictions, so leaving a loop once does not spoil the guess when the loop is entered again. Lookups are combinational. An update is written at the next rising clock edge.

Top module: `br_dir_predictor`

## Requirements
- R1: Address bits [7:2] select the table entry and bits [31:8] are the tag. `lk_hit` is 1 only when the selected entry is valid and its stored tag equals bits [31:8] of `lk_pc`.
- R2: A synchronous reset (`rst_n` low at a rising edge) invalidates every entry, so every lookup after reset misses until an update allocates an entry.
- R3: On a miss, `lk_taken` is 1 exactly when `lk_target` is below `lk_pc` as an unsigned number. An equal or higher target gives 0.
- R4: On a hit, `lk_taken` equals the entry's prediction bit (the left bit of the state) and does not depend on `lk_target`.
- R5: An update whose address misses allocates the entry. It writes the tag, sets valid, and sets both state bits to `up_taken`, so a lookup of that address in the next cycle hits and predicts `up_taken`.
- R6: An update that hits with the outcome equal to the prediction keeps the prediction and sets the last-outcome bit to the outcome.
- R7: An update that hits with the outcome differing from the prediction, while the last-outcome bit still agrees with the prediction, keeps the prediction and sets the last-outcome bit to the outcome.
- R8: An update that hits with the outcome differing from the prediction, while the last-outcome bit already disagrees with the prediction, sets both bits to the outcome, which flips the prediction.
- R9: An update to an address that shares an entry with a resident branch but has a different tag replaces that branch, which misses from then on.
- R10: The lookup outputs depend only on the current inputs and the table contents. An update changes the table at the next rising edge, so a lookup in the same cycle still sees the old contents.
- R11: While `up_valid` is 0, `up_pc` and `up_taken` have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 32 | Address of the branch being predicted |
| lk_target | input | 32 | Target address of that branch |
| lk_hit | output | 1 | Lookup found a valid entry with a matching tag |
| lk_taken | output | 1 | Predicted direction, 1 means taken |
| up_valid | input | 1 | An update is presented this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The checker properties assume that `up_valid` is held low while reset is asserted. They also assume that any address the table is asked about is word aligned, with bits [1:0] equal to 0. The bench drives only aligned addresses and sets all inputs on the falling edge, so the reset and update-effect properties see a clean boundary. For a lookup that targets the entry just written, the state-transition properties compare the next cycle's prediction with the state the update saw. The bench therefore places the repeated lookups of one address directly after the updates that exercise the hold, first-miss and flip paths.

// File: rtl/bp_pkg.sv
// Package: shared constants and the history-state type of the branch
// direction predictor. Assumes word-aligned instruction addresses.
package bp_pkg;
    // Number of always-zero address bits below the entry index
    localparam int ALIGN_BITS = 2;
    // Number of lookup/update read ports into the history table
    localparam int NUM_RD_PORTS = 2;

    // Two-bit history: pred is the direction guessed, last is the
    // direction the branch actually went on its latest resolution.
    typedef struct packed {
        logic pred;
        logic last;
    } hist_t;
endpackage

// File: rtl/bp_addr_split.sv
// Splits a branch address into table index and tag.
// Assumes bits below ALIGN_BITS are zero; they are discarded.
module bp_addr_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    localparam int TAG_W = ADDR_W - IDX_W - bp_pkg::ALIGN_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int IDX_LO = bp_pkg::ALIGN_BITS;
    localparam int TAG_LO = IDX_LO + IDX_W;

    logic unused_align_bits;

    // Field extraction: index sits just above the aligned bits, tag above it
    always_comb begin
        idx               = addr[TAG_LO-1:IDX_LO];
        tag               = addr[ADDR_W-1:TAG_LO];
        unused_align_bits = ^addr[IDX_LO-1:0];
    end
endmodule

// File: rtl/bp_static_rule.sv
// Static fallback direction: a branch whose target lies below its own
// address (a backward branch) is taken, all others are not taken.
// Assumes unsigned address comparison.
module bp_static_rule #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] target,
    output logic              taken
);
    // Backward-taken / forward-not-taken decision
    always_comb begin
        taken = (target < pc);
    end
endmodule

// File: rtl/bp_state_next.sv
// Next history state for an update. A miss seeds both bits with the
// outcome. A hit flips the prediction only on a second consecutive
// misprediction; otherwise only the last-outcome bit follows.
module bp_state_next (
    input  logic          hit,
    input  bp_pkg::hist_t cur,
    input  logic          outcome,
    output bp_pkg::hist_t nxt
);
    // Two-bit saturation-free hysteresis transition
    always_comb begin
        if (!hit) begin
            nxt.pred = outcome;
            nxt.last = outcome;
        end else if (outcome == cur.pred) begin
            nxt.pred = cur.pred;
            nxt.last = outcome;
        end else if (cur.last != cur.pred) begin
            nxt.pred = outcome;
            nxt.last = outcome;
        end else begin
            nxt.pred = cur.pred;
            nxt.last = outcome;
        end
    end
endmodule

// File: rtl/bp_hist_table.sv
// Direct-mapped history table with NUM_RD_PORTS combinational read
// ports and one write port. Each read port reports hit (valid and tag
// equal) and the stored state. Reset clears only the valid bits; tag and
// state storage is written on allocation before any hit can use it.
module bp_hist_table #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 24,
    localparam int DEPTH = 1 << IDX_W,
    localparam int NP    = bp_pkg::NUM_RD_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx [NP],
    input  logic [TAG_W-1:0]  rd_tag [NP],
    output logic              rd_hit [NP],
    output bp_pkg::hist_t     rd_st  [NP],
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  bp_pkg::hist_t     wr_st
);
    logic [DEPTH-1:0] vld;
    logic [TAG_W-1:0] tag_mem [DEPTH];
    bp_pkg::hist_t    st_mem  [DEPTH];

    // Valid flags: cleared by reset, set by any write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    // Tag and state storage: written on every accepted update
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            st_mem[wr_idx]  <= wr_st;
        end
    end

    // One identical combinational read port per requester
    for (genvar p = 0; p < NP; p++) begin : g_rd
        always_comb begin
            rd_hit[p] = vld[rd_idx[p]] && (tag_mem[rd_idx[p]] == rd_tag[p]);
            rd_st[p]  = st_mem[rd_idx[p]];
        end
    end
endmodule

// File: rtl/br_dir_predictor.sv
// Top: tagged direct-mapped 2-bit branch direction predictor with a
// static backward-taken fallback on misses. Port 0 of the table serves
// lookups, port 1 serves the update's read-modify-write. Assumes
// word-aligned addresses and at most one update per cycle.
module br_dir_predictor #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [ADDR_W-1:0] lk_target,
    output logic              lk_hit,
    output logic              lk_taken,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken
);
    localparam int TAG_W = ADDR_W - IDX_W - bp_pkg::ALIGN_BITS;
    localparam int NP    = bp_pkg::NUM_RD_PORTS;
    localparam int P_LK  = 0;
    localparam int P_UP  = 1;

    logic [ADDR_W-1:0] port_addr [NP];
    logic [IDX_W-1:0]  port_idx  [NP];
    logic [TAG_W-1:0]  port_tag  [NP];
    logic              port_hit  [NP];
    bp_pkg::hist_t     port_st   [NP];

    logic              static_taken;
    logic              upd_hit;
    logic              upd_pred;
    logic              upd_last;
    bp_pkg::hist_t     upd_next;

    // Route lookup and update addresses to their table ports
    always_comb begin
        port_addr[P_LK] = lk_pc;
        port_addr[P_UP] = up_pc;
    end

    for (genvar p = 0; p < NP; p++) begin : g_split
        bp_addr_split #(
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W)
        ) i_split (
            .addr (port_addr[p]),
            .idx  (port_idx[p]),
            .tag  (port_tag[p])
        );
    end

    bp_hist_table #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) i_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (port_idx),
        .rd_tag (port_tag),
        .rd_hit (port_hit),
        .rd_st  (port_st),
        .wr_en  (up_valid),
        .wr_idx (port_idx[P_UP]),
        .wr_tag (port_tag[P_UP]),
        .wr_st  (upd_next)
    );

    bp_static_rule #(
        .ADDR_W (ADDR_W)
    ) i_static (
        .pc     (lk_pc),
        .target (lk_target),
        .taken  (static_taken)
    );

    // Expose update-port read data for the state transition and checker
    always_comb begin
        upd_hit  = port_hit[P_UP];
        upd_pred = port_st[P_UP].pred;
        upd_last = port_st[P_UP].last;
    end

    bp_state_next i_next (
        .hit     (upd_hit),
        .cur     (port_st[P_UP]),
        .outcome (up_taken),
        .nxt     (upd_next)
    );

    // Prediction select: table state on a hit, static rule on a miss
    always_comb begin
        lk_hit   = port_hit[P_LK];
        lk_taken = port_hit[P_LK] ? port_st[P_LK].pred : static_taken;
    end
endmodule

// File: rtl/bp_checker.sv
// Checker for br_dir_predictor. Assumes up_valid is low during reset and
// addresses are word aligned. Attached to the top by bind below.
module bp_checker #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_pc,
    input logic [ADDR_W-1:0] lk_target,
    input logic              lk_hit,
    input logic              lk_taken,
    input logic              up_valid,
    input logic [ADDR_W-1:0] up_pc,
    input logic              up_taken,
    input logic              upd_hit,
    input logic              upd_pred,
    input logic              upd_last
);
    localparam int TAG_LO = IDX_W + 2;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit); // R2

    AST_MISS_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_taken == (lk_target < lk_pc))); // R3

    AST_ALLOC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && up_valid && !upd_hit) && lk_pc == $past(up_pc))
        |-> (lk_hit && lk_taken == $past(up_taken))); // R5

    AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && up_valid && upd_hit && (upd_pred == upd_last || upd_pred == up_taken))
         && lk_pc == $past(up_pc))
        |-> (lk_hit && lk_taken == $past(upd_pred))); // R7

    AST_PRED_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && up_valid && upd_hit && upd_pred != upd_last && upd_pred != up_taken)
         && lk_pc == $past(up_pc))
        |-> (lk_hit && lk_taken == $past(up_taken))); // R8

    AST_ALIAS_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && up_valid)
         && lk_pc[TAG_LO-1:2] == $past(up_pc[TAG_LO-1:2])
         && lk_pc[ADDR_W-1:TAG_LO] != $past(up_pc[ADDR_W-1:TAG_LO]))
        |-> !lk_hit); // R9

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && !up_valid) && $stable(lk_pc) && $stable(lk_target))
        |-> ($stable(lk_hit) && $stable(lk_taken))); // R11
endmodule

bind br_dir_predictor bp_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) i_bp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_target (lk_target),
    .lk_hit    (lk_hit),
    .lk_taken  (lk_taken),
    .up_valid  (up_valid),
    .up_pc     (up_pc),
    .up_taken  (up_taken),
    .upd_hit   (upd_hit),
    .upd_pred  (upd_pred),
    .upd_last  (upd_last)
);

// File: tb/test_br_dir_predictor.sv
// Scoreboard bench: the driver pushes the expected lookup result for each
// cycle it drives; the monitor pops and compares before the next edge.
module test_br_dir_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [31:0] lk_target = '0;
    logic        lk_hit;
    logic        lk_taken;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  taken;
        logic  hit;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    br_dir_predictor i_br_dir_predictor (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (lk_pc),
        .lk_target (lk_target),
        .lk_hit    (lk_hit),
        .lk_taken  (lk_taken),
        .up_valid  (up_valid),
        .up_pc     (up_pc),
        .up_taken  (up_taken)
    );

    localparam logic [31:0] PC_A = 32'h0000_1040;
    localparam logic [31:0] PC_B = 32'h2000_0080;
    localparam logic [31:0] PC_C = 32'h0001_1040;
    localparam logic [31:0] PC_D = 32'h0000_1044;
    localparam logic [31:0] PC_E = 32'h0000_0300;

    // Driver: one cycle of stimulus; queues the expected lookup result
    task automatic cyc(input logic [31:0] pc, input logic [31:0] tgt,
                       input logic et, input logic eh, input string req,
                       input logic uv, input logic [31:0] upc, input logic ut);
        exp_t e;
        @(negedge clk);
        lk_pc     = pc;
        lk_target = tgt;
        up_valid  = uv;
        up_pc     = upc;
        up_taken  = ut;
        e.taken = et;
        e.hit   = eh;
        e.req   = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compares outputs mid-cycle, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (lk_hit !== e.hit) begin
                n_fails++;
                $display("FAIL %s lk_hit actual=%0b expected=%0b", e.req, lk_hit, e.hit);
            end
            n_checks++;
            if (lk_taken !== e.taken) begin
                n_fails++;
                $display("FAIL %s lk_taken actual=%0b expected=%0b", e.req, lk_taken, e.taken);
            end
        end
    end

    // Stimulus sequence with hand-derived expectations
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(PC_A, 32'h0000_1000, 1, 0, "R2 empty after reset, backward", 0, 0, 0);
        cyc(PC_B, 32'h2000_0100, 0, 0, "R3 forward miss", 0, 0, 0);
        cyc(PC_E, PC_E,          0, 0, "R3 equal target miss", 0, 0, 0);
        cyc(PC_A, 32'h0000_1000, 1, 0, "R10 same-cycle old contents", 1, PC_A, 0);
        cyc(PC_A, 32'h0000_1000, 0, 1, "R5 allocate seeds not-taken", 1, PC_A, 1);
        cyc(PC_A, 32'h0000_1000, 0, 1, "R7 first miss keeps prediction", 1, PC_A, 1);
        cyc(PC_A, 32'h0000_1000, 1, 1, "R8 second miss flips", 1, PC_A, 0);
        cyc(PC_A, 32'h0000_1000, 1, 1, "R7 loop exit keeps taken", 1, PC_A, 1);
        cyc(PC_A, 32'h0000_2000, 1, 1, "R4 hit ignores forward target", 1, PC_A, 0);
        cyc(PC_A, 32'h0000_1000, 1, 1, "R6 after miss", 1, PC_A, 1);
        cyc(PC_A, 32'h0000_1000, 1, 1, "R6 correct resets last", 1, PC_A, 0);
        cyc(PC_A, 32'h0000_1000, 1, 1, "R6 still taken", 1, PC_A, 0);
        cyc(PC_A, 32'h0000_2000, 0, 1, "R8 flip to not-taken", 0, 0, 0);
        cyc(PC_C, 32'h0000_0000, 1, 0, "R1 tag mismatch misses", 0, 0, 0);
        cyc(PC_D, 32'h0000_2000, 0, 0, "R1 other index misses", 0, 0, 0);
        cyc(PC_C, 32'h0000_0000, 1, 0, "R9 alias before allocate", 1, PC_C, 0);
        cyc(PC_C, 32'h0000_0000, 0, 1, "R9 alias now resident", 0, 0, 0);
        cyc(PC_A, 32'h0000_1000, 1, 0, "R9 evicted branch misses", 0, PC_C, 1);
        cyc(PC_C, 32'h0000_0000, 0, 1, "R11 idle update ignored", 0, PC_C, 1);
        cyc(PC_C, 32'h0000_0000, 0, 1, "R11 still unchanged", 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule